// File: doc/BRIEF.md
# CPU Exception Request Arbiter

This block sits next to a CPU core's sequencer. At every instruction boundary, and at the end of every exception sequence, it picks the one pending exception the core must take next. It then reports the exception's type and the index into the vector table. Four sources compete:

- the reset pin;
- the trace bit;
- a level-held interrupt request, which carries its own vector;
- a trap strobe, which carries a small trap number.

Fetching the vector, stacking the context and decoding opcodes are left to the core. The block only makes the decision and computes the index.

A boundary's eligibility depends on more than a fixed ranking. The core tags the boundary with the class of opcode it just retired:

- After a return from exception, a set trace bit does not trace.
- After an opcode that writes the control register (a logical operation or a load into it), the interrupt line is not looked at.
- The interrupt line is also ignored at the first boundary after reset handling.
- Tracing also requires the interrupt control mode to be 2 or 3.

Reset is different from the other sources. It is not tied to a boundary. The first clock edge after the pin rises produces the reset decision.

Top module: `exc_arbiter`

## Requirements
- R1: While `res_n` is low, `take_o` stays 0 and every other input is ignored. A trap strobe seen while the pin is low, or in the reset-take cycle, is discarded.
- R2: At the first rising clock edge with `res_n` high after it was low, `take_o` pulses for exactly one cycle with `kind_o` = 1 (reset) and `vec_o` = VEC_RESET (0).
- R3: Outside the reset pulse, `take_o` rises only in the cycle after a clock edge where `bound_stb_i` was sampled high. It lasts one cycle. A held request with no boundary produces nothing.
- R4: When several sources are eligible at one boundary, only the highest is reported. The order is trace, then interrupt, then trap. A trap that loses stays latched with its number, and the interrupt line is evaluated again at the next boundary.
- R5: Trace is eligible only if `trace_bit_i` is 1 and `icm_i` is 2 or 3. With `icm_i` at 0 or 1, a set trace bit is not taken.
- R6: No trace is taken at a boundary whose `retire_cls_i` is 2 (return from exception).
- R7: No interrupt is taken at a boundary whose `retire_cls_i` is 1 (logical operation on, or load into, the control register).
- R8: No interrupt is taken at the first boundary after the reset pulse. The next boundary takes it if the request is still held.
- R9: A trap strobe is always accepted. If it comes with a boundary, it is eligible at that same boundary. Otherwise it is held until a boundary, where no retire class blocks it. Its vector is VEC_TRAP_BASE (8) + `trap_num_i`, and it is taken only once.
- R10: An interrupt's vector is `irq_vec_i` as sampled at the boundary. A trace's vector is VEC_TRACE (5).
- R11: `kind_o` codes are 0 none, 1 reset, 2 trace, 3 interrupt and 4 trap. When `take_o` is 0, `kind_o` and `vec_o` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| res_n | input | 1 | Active-low reset pin, also clears all state |
| trace_bit_i | input | 1 | Trace bit from the status register |
| icm_i | input | 2 | Interrupt control mode |
| irq_req_i | input | 1 | Interrupt request, held by the source until served |
| irq_vec_i | input | VEC_W | Vector index supplied with the interrupt |
| trap_stb_i | input | 1 | One-cycle strobe when a trap opcode executes |
| trap_num_i | input | TRAP_NUM_W | Trap number carried by the strobe |
| bound_stb_i | input | 1 | End of instruction or end of exception sequence |
| retire_cls_i | input | 2 | Class of the opcode just retired: 1 control-register write, 2 return, else plain |
| take_o | output | 1 | One-cycle pulse: take the exception now |
| kind_o | output | 3 | Type of exception taken |
| vec_o | output | VEC_W | Vector table index |

## Verification
The bench raises every source at once inside a single boundary, then removes them one by one. A broken priority chain would report two kinds at once or a lower source first, and a trap that was wrongly consumed would never reappear. The bench sweeps the mode through all four values, and it uses return and control-write boundaries to catch a qualifier tied to the wrong class or the wrong mode threshold. It holds the interrupt line across reset release, which exposes a missing post-reset mask (interrupt on the first boundary) as well as a mask that never clears. It also drops the pin in the middle of a run while a trap is held, to show whether a stale trap survives reset.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;

   typedef enum logic [2:0] {
      KIND_NONE  = 3'd0,
      KIND_RESET = 3'd1,
      KIND_TRACE = 3'd2,
      KIND_IRQ   = 3'd3,
      KIND_TRAP  = 3'd4
   } exc_kind_e;

   // retired-opcode classes that change eligibility
   localparam logic [1:0] CLS_CTRL_WR = 2'd1;
   localparam logic [1:0] CLS_RETURN  = 2'd2;

   // source slots, index 0 is the highest priority below reset
   localparam int SRC_TRACE = 0;
   localparam int SRC_IRQ   = 1;
   localparam int SRC_TRAP  = 2;
   localparam int NUM_SRC   = 3;

endpackage

// File: rtl/exc_arb_trap_hold.sv
module exc_arb_trap_hold #(
   parameter int NUM_W = 2
) (
   input  logic             clk,
   input  logic             res_n,
   input  logic             run_i,
   input  logic             stb_i,
   input  logic [NUM_W-1:0] num_i,
   input  logic             consume_i,
   output logic             pend_o,
   output logic [NUM_W-1:0] num_o
);

   logic             pend_q;
   logic [NUM_W-1:0] num_q;

   always_ff @(posedge clk or negedge res_n) begin
      if (!res_n) begin
         pend_q <= 1'b0;
         num_q  <= '0;
      end else if (run_i) begin
         if (consume_i) begin
            pend_q <= 1'b0;
         end else if (stb_i) begin
            pend_q <= 1'b1;
            num_q  <= num_i;
         end
      end
   end

   // a fresh strobe is usable at the boundary it arrives with
   assign pend_o = pend_q | stb_i;
   assign num_o  = stb_i ? num_i : num_q;

endmodule

// File: rtl/exc_arb_qualify.sv
module exc_arb_qualify
   import exc_arb_pkg::*;
#(
   parameter int MODE_W         = 2,
   parameter int TRACE_MIN_MODE = 2
) (
   input  logic               run_i,
   input  logic               bound_i,
   input  logic               trace_bit_i,
   input  logic [MODE_W-1:0]  mode_i,
   input  logic [1:0]         cls_i,
   input  logic               irq_i,
   input  logic               post_rst_i,
   input  logic               trap_pend_i,
   output logic [NUM_SRC-1:0] req_o
);

   logic at_edge;

   assign at_edge = run_i & bound_i;

   always_comb begin
      req_o = '0;
      if (at_edge) begin
         req_o[SRC_TRACE] = trace_bit_i
                          && (int'(mode_i) >= TRACE_MIN_MODE)
                          && (cls_i != CLS_RETURN);
         req_o[SRC_IRQ]   = irq_i
                          && (cls_i != CLS_CTRL_WR)
                          && !post_rst_i;
         req_o[SRC_TRAP]  = trap_pend_i;
      end
   end

endmodule

// File: rtl/exc_arb_select.sv
module exc_arb_select #(
   parameter int N = 3
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] gnt_o,
   output logic         any_o
);

   logic [N:0] seen;

   assign seen[0] = 1'b0;

   for (genvar g = 0; g < N; g++) begin : g_chain
      assign gnt_o[g]    = req_i[g] & ~seen[g];
      assign seen[g + 1] = seen[g] | req_i[g];
   end

   assign any_o = seen[N];

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_arb_pkg::*;
#(
   parameter int VEC_W          = 8,
   parameter int TRAP_NUM_W     = 2,
   parameter int VEC_RESET      = 0,
   parameter int VEC_TRACE      = 5,
   parameter int VEC_TRAP_BASE  = 8,
   parameter int TRACE_MIN_MODE = 2
) (
   input  logic                  clk,
   input  logic                  res_n,
   input  logic                  trace_bit_i,
   input  logic [1:0]            icm_i,
   input  logic                  irq_req_i,
   input  logic [VEC_W-1:0]      irq_vec_i,
   input  logic                  trap_stb_i,
   input  logic [TRAP_NUM_W-1:0] trap_num_i,
   input  logic                  bound_stb_i,
   input  logic [1:0]            retire_cls_i,
   output logic                  take_o,
   output logic [2:0]            kind_o,
   output logic [VEC_W-1:0]      vec_o
);

   localparam int VEC_SPAN = 1 << VEC_W;
   localparam int TRAP_CNT = 1 << TRAP_NUM_W;
   localparam logic [VEC_W-1:0] RESET_V     = VEC_W'(VEC_RESET);
   localparam logic [VEC_W-1:0] TRACE_V     = VEC_W'(VEC_TRACE);
   localparam logic [VEC_W-1:0] TRAP_BASE_V = VEC_W'(VEC_TRAP_BASE);

   if (VEC_W < 2 || VEC_W > 16) begin : g_bad_vec_w
      $error("exc_arbiter: VEC_W out of range");
   end
   if (VEC_TRAP_BASE + TRAP_CNT > VEC_SPAN) begin : g_bad_trap
      $error("exc_arbiter: trap vectors exceed vector space");
   end
   if (VEC_TRACE >= VEC_SPAN || VEC_RESET >= VEC_SPAN) begin : g_bad_fixed
      $error("exc_arbiter: fixed vector exceeds vector space");
   end
   if (TRACE_MIN_MODE < 0 || TRACE_MIN_MODE > 3) begin : g_bad_mode
      $error("exc_arbiter: TRACE_MIN_MODE out of range");
   end

   logic                  rst_pend_q;
   logic                  post_rst_q;
   logic                  run;
   logic                  trap_pend;
   logic [TRAP_NUM_W-1:0] trap_num;
   logic [NUM_SRC-1:0]    req;
   logic [NUM_SRC-1:0]    gnt;
   logic                  any_gnt;
   exc_kind_e             nxt_kind;
   logic [VEC_W-1:0]      nxt_vec;

   assign run = ~rst_pend_q;

   exc_arb_trap_hold #(
      .NUM_W (TRAP_NUM_W)
   ) trap_i (
      .clk       (clk),
      .res_n     (res_n),
      .run_i     (run),
      .stb_i     (trap_stb_i),
      .num_i     (trap_num_i),
      .consume_i (gnt[SRC_TRAP]),
      .pend_o    (trap_pend),
      .num_o     (trap_num)
   );

   exc_arb_qualify #(
      .MODE_W         (2),
      .TRACE_MIN_MODE (TRACE_MIN_MODE)
   ) qual_i (
      .run_i       (run),
      .bound_i     (bound_stb_i),
      .trace_bit_i (trace_bit_i),
      .mode_i      (icm_i),
      .cls_i       (retire_cls_i),
      .irq_i       (irq_req_i),
      .post_rst_i  (post_rst_q),
      .trap_pend_i (trap_pend),
      .req_o       (req)
   );

   exc_arb_select #(
      .N (NUM_SRC)
   ) sel_i (
      .req_i (req),
      .gnt_o (gnt),
      .any_o (any_gnt)
   );

   always_comb begin
      nxt_kind = KIND_NONE;
      nxt_vec  = '0;
      if (gnt[SRC_TRACE]) begin
         nxt_kind = KIND_TRACE;
         nxt_vec  = TRACE_V;
      end else if (gnt[SRC_IRQ]) begin
         nxt_kind = KIND_IRQ;
         nxt_vec  = irq_vec_i;
      end else if (gnt[SRC_TRAP]) begin
         nxt_kind = KIND_TRAP;
         nxt_vec  = TRAP_BASE_V + VEC_W'(trap_num);
      end
   end

   always_ff @(posedge clk or negedge res_n) begin
      if (!res_n) begin
         rst_pend_q <= 1'b1;
         post_rst_q <= 1'b0;
         take_o     <= 1'b0;
         kind_o     <= KIND_NONE;
         vec_o      <= '0;
      end else if (rst_pend_q) begin
         rst_pend_q <= 1'b0;
         post_rst_q <= 1'b1;
         take_o     <= 1'b1;
         kind_o     <= KIND_RESET;
         vec_o      <= RESET_V;
      end else begin
         take_o <= any_gnt;
         kind_o <= nxt_kind;
         vec_o  <= nxt_vec;
         if (bound_stb_i) begin
            post_rst_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/exc_arbiter_chk.sv
module exc_arbiter_chk
   import exc_arb_pkg::*;
#(
   parameter int VEC_W          = 8,
   parameter int TRAP_NUM_W     = 2,
   parameter int VEC_RESET      = 0,
   parameter int VEC_TRACE      = 5,
   parameter int VEC_TRAP_BASE  = 8,
   parameter int TRACE_MIN_MODE = 2
) (
   input logic             clk,
   input logic             res_n,
   input logic             trace_bit_i,
   input logic [1:0]       icm_i,
   input logic [VEC_W-1:0] irq_vec_i,
   input logic             bound_stb_i,
   input logic [1:0]       retire_cls_i,
   input logic             take_o,
   input logic [2:0]       kind_o,
   input logic [VEC_W-1:0] vec_o
);

   localparam int TRAP_TOP = VEC_TRAP_BASE + (1 << TRAP_NUM_W);

   always @(posedge clk) begin
      if (!res_n) begin
         AST_QUIET_IN_RESET: assert (take_o !== 1'b1); // R1
      end
   end

   AST_RESET_PULSE: assert property (@(posedge clk) disable iff (!res_n)
      $rose(res_n) |=> take_o && kind_o == KIND_RESET && vec_o == VEC_W'(VEC_RESET)); // R2

   AST_RESET_ONCE: assert property (@(posedge clk) disable iff (!res_n)
      take_o && kind_o == KIND_RESET |=> kind_o != KIND_RESET); // R2

   AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!res_n)
      take_o && kind_o != KIND_RESET |-> $past(bound_stb_i)); // R3

   AST_TRACE_BEATS_IRQ: assert property (@(posedge clk) disable iff (!res_n)
      take_o && kind_o == KIND_IRQ |->
      !$past(trace_bit_i && int'(icm_i) >= TRACE_MIN_MODE && retire_cls_i != CLS_RETURN)); // R4

   AST_TRACE_MODE: assert property (@(posedge clk) disable iff (!res_n)
      take_o && kind_o == KIND_TRACE |-> int'($past(icm_i)) >= TRACE_MIN_MODE); // R5

   AST_NO_TRACE_AFTER_RETURN: assert property (@(posedge clk) disable iff (!res_n)
      take_o && kind_o == KIND_TRACE |-> $past(retire_cls_i) != CLS_RETURN); // R6

   AST_NO_IRQ_AFTER_CTRL_WR: assert property (@(posedge clk) disable iff (!res_n)
      take_o && kind_o == KIND_IRQ |-> $past(retire_cls_i) != CLS_CTRL_WR); // R7

   AST_TRAP_VEC_RANGE: assert property (@(posedge clk) disable iff (!res_n)
      take_o && kind_o == KIND_TRAP |->
      int'(vec_o) >= VEC_TRAP_BASE && int'(vec_o) < TRAP_TOP); // R9

   AST_IRQ_VEC: assert property (@(posedge clk) disable iff (!res_n)
      take_o && kind_o == KIND_IRQ |-> vec_o == $past(irq_vec_i)); // R10

   AST_TRACE_VEC: assert property (@(posedge clk) disable iff (!res_n)
      take_o && kind_o == KIND_TRACE |-> vec_o == VEC_W'(VEC_TRACE)); // R10

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!res_n)
      !take_o |-> kind_o == KIND_NONE && vec_o == '0); // R11

endmodule

bind exc_arbiter exc_arbiter_chk #(
   .VEC_W          (VEC_W),
   .TRAP_NUM_W     (TRAP_NUM_W),
   .VEC_RESET      (VEC_RESET),
   .VEC_TRACE      (VEC_TRACE),
   .VEC_TRAP_BASE  (VEC_TRAP_BASE),
   .TRACE_MIN_MODE (TRACE_MIN_MODE)
) chk_i (
   .clk          (clk),
   .res_n        (res_n),
   .trace_bit_i  (trace_bit_i),
   .icm_i        (icm_i),
   .irq_vec_i    (irq_vec_i),
   .bound_stb_i  (bound_stb_i),
   .retire_cls_i (retire_cls_i),
   .take_o       (take_o),
   .kind_o       (kind_o),
   .vec_o        (vec_o)
);

// File: tb/exc_arbiter_tb_top.sv
module exc_arbiter_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int VEC_W      = 8;
   localparam int TNW        = 2;
   localparam int WATCHDOG   = 20000;

   logic           clk = 1'b0;
   logic           res_n = 1'b0;
   logic           trace_bit = 1'b0;
   logic [1:0]     icm = 2'd0;
   logic           irq_req = 1'b0;
   logic [VEC_W-1:0] irq_vec = '0;
   logic           trap_stb = 1'b0;
   logic [TNW-1:0] trap_num = '0;
   logic           bound = 1'b0;
   logic [1:0]     cls = 2'd0;
   logic           take;
   logic [2:0]     kind;
   logic [VEC_W-1:0] vec;

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";

   always #(CLK_PERIOD / 2) clk = ~clk;

   exc_arbiter dut_i (
      .clk          (clk),
      .res_n        (res_n),
      .trace_bit_i  (trace_bit),
      .icm_i        (icm),
      .irq_req_i    (irq_req),
      .irq_vec_i    (irq_vec),
      .trap_stb_i   (trap_stb),
      .trap_num_i   (trap_num),
      .bound_stb_i  (bound),
      .retire_cls_i (cls),
      .take_o       (take),
      .kind_o       (kind),
      .vec_o        (vec)
   );

   // behavioural reference model, updated at each rising edge
   bit m_rst_pend = 1'b1;
   bit m_post     = 1'b0;
   int trapq[$];
   bit exp_take = 1'b0;
   int exp_kind = 0;
   int exp_vec  = 0;

   always @(posedge clk) begin
      bit tr_ok, ir_ok, tp_ok;
      if (!res_n) begin
         m_rst_pend = 1'b1;
         m_post     = 1'b0;
         trapq.delete();
         exp_take = 1'b0; exp_kind = 0; exp_vec = 0;
      end else if (m_rst_pend) begin
         m_rst_pend = 1'b0;
         m_post     = 1'b1;
         exp_take = 1'b1; exp_kind = 1; exp_vec = 0;
      end else begin
         exp_take = 1'b0; exp_kind = 0; exp_vec = 0;
         if (trap_stb) begin
            trapq.delete();
            trapq.push_back(int'(trap_num));
         end
         tr_ok = bound && trace_bit && icm >= 2 && cls != 2'd2;
         ir_ok = bound && irq_req && cls != 2'd1 && !m_post;
         tp_ok = bound && trapq.size() > 0;
         if (tr_ok) begin
            exp_take = 1'b1; exp_kind = 2; exp_vec = 5;
         end else if (ir_ok) begin
            exp_take = 1'b1; exp_kind = 3; exp_vec = int'(irq_vec);
         end else if (tp_ok) begin
            exp_take = 1'b1; exp_kind = 4; exp_vec = 8 + trapq[0];
            trapq.delete();
         end
         if (bound) m_post = 1'b0;
      end
   end

   task automatic compare_model();
      checks++;
      if (take !== exp_take || kind !== exp_kind[2:0] || vec !== exp_vec[VEC_W-1:0]) begin
         errors++;
         $display("FAIL %s: take/kind/vec = %0b/%0d/%0d, expected %0b/%0d/%0d",
                  cur_req, take, kind, vec, exp_take, exp_kind, exp_vec);
      end
   endtask

   task automatic tick(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         compare_model();
      end
   endtask

   // directed check with literal expectations from the requirements
   task automatic expect_out(string r, bit t, int k, int v);
      checks++;
      if (take !== t || kind !== k[2:0] || vec !== v[VEC_W-1:0]) begin
         errors++;
         $display("FAIL %s: take/kind/vec = %0b/%0d/%0d, expected %0b/%0d/%0d",
                  r, take, kind, vec, t, k, v);
      end
   endtask

   // one boundary with the given retire class; returns with its outcome visible
   task automatic pulse_bound(logic [1:0] c);
      bound = 1'b1;
      cls   = c;
      tick();
      bound = 1'b0;
      cls   = 2'd0;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      summary();
      $finish;
   end

   initial begin
      // R1: everything active while the pin is low
      cur_req = "R1";
      irq_req = 1'b1; trace_bit = 1'b1; icm = 2'd3; bound = 1'b1;
      trap_stb = 1'b1; trap_num = 2'd2;
      tick(4);
      expect_out("R1", 1'b0, 0, 0);
      bound = 1'b0; trap_stb = 1'b0; trace_bit = 1'b0;
      irq_vec = 8'd40;

      // R2: single reset pulse on release
      cur_req = "R2";
      res_n = 1'b1;
      tick();
      expect_out("R2", 1'b1, 1, 0);
      tick();
      expect_out("R2", 1'b0, 0, 0);

      // R8: held interrupt masked at first boundary after reset
      cur_req = "R8";
      pulse_bound(2'd0);
      expect_out("R8", 1'b0, 0, 0);
      tick();
      pulse_bound(2'd0);
      expect_out("R8", 1'b1, 3, 40);
      tick();

      // R3: held request with no boundary gives nothing
      cur_req = "R3";
      tick(5);
      expect_out("R3", 1'b0, 0, 0);
      irq_req = 1'b0;
      tick();

      // R5: trace across all modes
      cur_req = "R5";
      trace_bit = 1'b1;
      for (int m = 0; m < 4; m++) begin
         icm = 2'(m);
         pulse_bound(2'd0);
         if (m >= 2) expect_out("R5", 1'b1, 2, 5);
         else        expect_out("R5", 1'b0, 0, 0);
         tick();
      end

      // R6: return boundary suppresses trace, interrupt wins instead
      cur_req = "R6";
      icm = 2'd2; irq_req = 1'b1; irq_vec = 8'd77;
      pulse_bound(2'd2);
      expect_out("R6", 1'b1, 3, 77);
      pulse_bound(2'd0);
      expect_out("R6", 1'b1, 2, 5);
      tick();

      // R7: control-register write boundary masks interrupt
      cur_req = "R7";
      trace_bit = 1'b0;
      pulse_bound(2'd1);
      expect_out("R7", 1'b0, 0, 0);
      pulse_bound(2'd0);
      expect_out("R7", 1'b1, 3, 77);
      irq_req = 1'b0;
      tick();

      // R9: traps with and without coincident boundary
      cur_req = "R9";
      trap_stb = 1'b1; trap_num = 2'd3;
      pulse_bound(2'd0);
      trap_stb = 1'b0;
      expect_out("R9", 1'b1, 4, 11);
      trap_stb = 1'b1; trap_num = 2'd1;
      tick();
      trap_stb = 1'b0;
      tick(3);
      expect_out("R9", 1'b0, 0, 0);
      pulse_bound(2'd1);
      expect_out("R9", 1'b1, 4, 9);
      pulse_bound(2'd0);
      expect_out("R9", 1'b0, 0, 0);
      tick();

      // R4: all three at once, then peel away
      cur_req = "R4";
      trap_stb = 1'b1; trap_num = 2'd2;
      tick();
      trap_stb = 1'b0;
      trace_bit = 1'b1; icm = 2'd3; irq_req = 1'b1; irq_vec = 8'd100;
      pulse_bound(2'd0);
      expect_out("R4", 1'b1, 2, 5);
      trace_bit = 1'b0;
      pulse_bound(2'd0);
      expect_out("R4", 1'b1, 3, 100);
      irq_req = 1'b0;
      pulse_bound(2'd0);
      expect_out("R4", 1'b1, 4, 10);
      pulse_bound(2'd0);
      expect_out("R4", 1'b0, 0, 0);
      tick();

      // R10: interrupt vector taken from the input
      cur_req = "R10";
      irq_req = 1'b1;
      irq_vec = 8'd0;   pulse_bound(2'd3); expect_out("R10", 1'b1, 3, 0);
      irq_vec = 8'd255; pulse_bound(2'd0); expect_out("R10", 1'b1, 3, 255);
      irq_vec = 8'd17;  pulse_bound(2'd0); expect_out("R10", 1'b1, 3, 17);
      irq_req = 1'b0;

      // R11: idle outputs are zero
      cur_req = "R11";
      tick(3);
      expect_out("R11", 1'b0, 0, 0);

      // R1 again: mid-run reset discards a held trap
      cur_req = "R1";
      trap_stb = 1'b1; trap_num = 2'd0;
      tick();
      trap_stb = 1'b0;
      res_n = 1'b0;
      bound = 1'b1;
      tick(3);
      expect_out("R1", 1'b0, 0, 0);
      bound = 1'b0;
      cur_req = "R2";
      res_n = 1'b1;
      tick();
      expect_out("R2", 1'b1, 1, 0);
      pulse_bound(2'd0);
      expect_out("R1", 1'b0, 0, 0);
      tick(2);

      summary();
      $finish;
   end

endmodule